// File: doc/BRIEF.md
# UART Host Register Block

This block is the processor-facing side of a serial port. A host or a DMA engine reaches six 16-bit registers through a small word-addressed port. Those registers hold the received character, the character to send, a status word, interrupt enables, the bit-period divisor and a packet-end marker. Characters written by the host wait in a one-deep holding register. They pass to an external transmit shifter as soon as that shifter is idle. Characters from an external receive shifter land in a holding register that keeps the last complete character while the next one is still arriving.

A single interrupt line is the OR of the status conditions whose enables are set. Two level outputs tell a DMA engine whether a character is waiting to be read and whether the transmit side can take another write. Serial shifting and line drivers are outside this block.

Top module: `uart_host_regs`

## Requirements
- R1: Register word offsets are: 0 received data, 1 transmit data, 2 status, 3 control, 4 divisor, 5 packet-end marker. Read data appears on `bus_rdata` on the clock edge after the cycle in which `bus_rd` is high. Offsets 6 and 7, the transmit-data offset, and all unused upper bits read as zero.
- R2: The divisor resets to 433 and drives `baud_div`. A write at offset 4 takes effect one edge later and reads back unchanged.
- R3: Status bit 6 (transmit ready) is high while the holding register is empty. A write at offset 1 when the holding register is empty and `tx_busy` is low produces a one-cycle `tx_load` pulse with `tx_data` equal to the written character. `wr_room` follows status bit 6.
- R4: A write at offset 1 while the holding register is full is dropped and sets sticky status bit 4 (transmit overrun). The character already held is the next one sent.
- R5: Status bit 5 (transmitter empty) is high only when the holding register is empty, `tx_busy` is low and no load is in flight. It is never high while bit 6 is low.
- R6: A `rx_valid` pulse stores `rx_char` as the received data and sets status bit 7 (receive ready). `rd_avail` follows status bit 7.
- R7: Reading offset 0 clears status bit 7, unless a new character arrives in the same cycle.
- R8: A character that arrives while bit 7 is still set overwrites the stored one and sets sticky status bit 3 (receive overrun).
- R9: `rx_pe` and `rx_fe` given with a character set sticky status bits 0 and 1. Status bit 8 is the OR of bits 0, 1, 3 and 4.
- R10: Any write at offset 2 clears status bits 0, 1, 3, 4 and 12.
- R11: Sticky status bit 12 sets when a received character, or a character handed to the transmitter, equals the packet-end register.
- R12: Control has an enable at each used status bit position (mask 0x11FB; other bits read zero). `irq` goes high one edge after any enabled status bit is set, and is low when no enabled bit is set.
- R13: After reset, status reads 0x0060, control reads 0, and `irq`, `tx_load` and `rd_avail` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request, active high |
| rd_avail | output | 1 | A received character is waiting |
| wr_room | output | 1 | Transmit holding register can take a character |
| baud_div | output | DIV_W | Bit period minus one, in clocks |
| tx_load | output | 1 | One-cycle pulse handing `tx_data` to the shifter |
| tx_data | output | DATA_W | Character for the transmit shifter |
| tx_busy | input | 1 | Transmit shifter is sending, high from the cycle after `tx_load` |
| rx_valid | input | 1 | One-cycle pulse: `rx_char` is complete |
| rx_char | input | DATA_W | Received character |
| rx_pe | input | 1 | Parity error for this character |
| rx_fe | input | 1 | Framing error for this character |

## Verification
A holding flag that is wrong shows at the ports at once. It appears as a missing or doubled `tx_load`, a wrong status bit 6 or 7, or a ready output that disagrees with the status word on the next read. A sticky bit that is never set or never cleared shows in the first status read after the event or the clear. It also shows in `irq` one edge after an enable is written. Overwrite and drop rules are observed by reading the received data or watching which character reaches `tx_data`, so a character kept or lost by mistake shows within a few cycles.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int REG_W = 16;

  typedef enum logic [2:0] {
    OFS_RXDATA  = 3'd0,
    OFS_TXDATA  = 3'd1,
    OFS_STATUS  = 3'd2,
    OFS_CONTROL = 3'd3,
    OFS_DIVISOR = 3'd4,
    OFS_EOPCHAR = 3'd5
  } reg_ofs_e;

  localparam int SB_PE   = 0;
  localparam int SB_FE   = 1;
  localparam int SB_ROE  = 3;
  localparam int SB_TOE  = 4;
  localparam int SB_TMT  = 5;
  localparam int SB_TRDY = 6;
  localparam int SB_RRDY = 7;
  localparam int SB_ERR  = 8;
  localparam int SB_EOP  = 12;

  localparam int NUM_STICKY = 5;
  localparam int STICKY_POS [NUM_STICKY] = '{SB_PE, SB_FE, SB_ROE, SB_TOE, SB_EOP};

  localparam logic [REG_W-1:0] USED_MASK = 16'h11FB;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_char,
  input  logic              tx_busy,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              trdy,
  output logic              tmt,
  output logic              ovr_pulse
);
  logic              full_q;
  logic [DATA_W-1:0] hold_q;
  logic              hand_off;

  assign hand_off = full_q && !tx_busy && !tx_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q    <= 1'b0;
      hold_q    <= '0;
      tx_load   <= 1'b0;
      tx_data   <= '0;
      ovr_pulse <= 1'b0;
    end else begin
      tx_load   <= 1'b0;
      ovr_pulse <= 1'b0;
      if (hand_off) begin
        tx_load <= 1'b1;
        tx_data <= hold_q;
        full_q  <= 1'b0;
      end
      if (wr_en) begin
        if (full_q) begin
          ovr_pulse <= 1'b1;
        end else begin
          hold_q <= wr_char;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign trdy = !full_q;
  assign tmt  = !full_q && !tx_busy && !tx_load;

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $past(!tx_busy)); // R3
  AST_TMT_NEEDS_TRDY: assert property (@(posedge clk) disable iff (rst)
    tmt |-> trdy); // R5
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !trdy && !hand_off) |=> (!trdy && $stable(hold_q))); // R4
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              take,
  output logic [DATA_W-1:0] rx_q,
  output logic              rrdy,
  output logic              roe_set
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
      rrdy <= 1'b0;
    end else if (rx_valid) begin
      rx_q <= rx_char;
      rrdy <= 1'b1;
    end else if (take) begin
      rrdy <= 1'b0;
    end
  end

  assign roe_set = rx_valid && rrdy && !take;

  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (rrdy && rx_q == $past(rx_char))); // R6
  AST_RX_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (take && !rx_valid) |=> !rrdy); // R7
endmodule

// File: rtl/uart_status_irq.sv
module uart_status_irq
  import uart_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_STICKY-1:0] set_v,
  input  logic                  clr,
  input  logic                  trdy,
  input  logic                  tmt,
  input  logic                  rrdy,
  input  logic [REG_W-1:0]      ctrl,
  output logic [REG_W-1:0]      status,
  output logic                  irq
);
  logic [NUM_STICKY-1:0] sticky_q;

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst) sticky_q[g] <= 1'b0;
      else     sticky_q[g] <= set_v[g] | (sticky_q[g] & ~clr);
    end
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < NUM_STICKY; i++) status[STICKY_POS[i]] = sticky_q[i];
    status[SB_TMT]  = tmt;
    status[SB_TRDY] = trdy;
    status[SB_RRDY] = rrdy;
    status[SB_ERR]  = sticky_q[0] | sticky_q[1] | sticky_q[2] | sticky_q[3];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & ctrl);
  end

  AST_CLEAR_ROE: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_v[2]) |=> !status[SB_ROE]); // R10
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|ctrl)); // R12
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 433
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              rd_avail,
  output logic              wr_room,
  output logic [DIV_W-1:0]  baud_div,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_busy,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              rx_pe,
  input  logic              rx_fe
);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(OFS_RXDATA);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(OFS_TXDATA);
  localparam logic [ADDR_W-1:0] A_ST   = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CONTROL);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIVISOR);
  localparam logic [ADDR_W-1:0] A_EOP  = ADDR_W'(OFS_EOPCHAR);

  logic [REG_W-1:0]      ctrl_q;
  logic [DIV_W-1:0]      div_q;
  logic [DATA_W-1:0]     eop_q;
  logic [DATA_W-1:0]     rx_q;
  logic [REG_W-1:0]      status;
  logic                  trdy, tmt, rrdy, toe_set, roe_set, eop_hit;
  logic [NUM_STICKY-1:0] set_v;
  logic                  wr_tx, wr_st, rd_rx;

  assign wr_tx = bus_wr && (bus_addr == A_TX);
  assign wr_st = bus_wr && (bus_addr == A_ST);
  assign rd_rx = bus_rd && (bus_addr == A_RX);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RESET);
      eop_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata & USED_MASK;
      if (bus_addr == A_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
      if (bus_addr == A_EOP)  eop_q  <= bus_wdata[DATA_W-1:0];
    end
  end

  uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .wr_en(wr_tx), .wr_char(bus_wdata[DATA_W-1:0]),
    .tx_busy(tx_busy), .tx_load(tx_load), .tx_data(tx_data),
    .trdy(trdy), .tmt(tmt), .ovr_pulse(toe_set)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .take(rd_rx), .rx_q(rx_q), .rrdy(rrdy), .roe_set(roe_set)
  );

  assign eop_hit = (rx_valid && rx_char == eop_q) || (tx_load && tx_data == eop_q);
  assign set_v   = {eop_hit, toe_set, roe_set, rx_valid & rx_fe, rx_valid & rx_pe};

  uart_status_irq u_st (
    .clk(clk), .rst(rst), .set_v(set_v), .clr(wr_st),
    .trdy(trdy), .tmt(tmt), .rrdy(rrdy), .ctrl(ctrl_q),
    .status(status), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_RX:    bus_rdata <= REG_W'(rx_q);
        A_ST:    bus_rdata <= status;
        A_CTRL:  bus_rdata <= ctrl_q;
        A_DIV:   bus_rdata <= REG_W'(div_q);
        A_EOP:   bus_rdata <= REG_W'(eop_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign rd_avail = rrdy;
  assign wr_room  = trdy;
  assign baud_div = div_q;

  AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr > A_EOP) |=> (bus_rdata == '0)); // R1
  AST_DIV_APPLIED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DIV) |=> (baud_div == $past(bus_wdata[DIV_W-1:0]))); // R2
  AST_READY_MATCH: assert property (@(posedge clk) disable iff (rst)
    (rd_avail == status[SB_RRDY]) && (wr_room == status[SB_TRDY])); // R6
endmodule

// File: tb/uart_host_regs_tb.sv
module uart_host_regs_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  bus_addr = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        irq, rd_avail, wr_room, tx_load, tx_busy = 0;
  logic [15:0] baud_div;
  logic [7:0]  tx_data, rx_char = 0;
  logic        rx_valid = 0, rx_pe = 0, rx_fe = 0;

  int n_chk = 0, n_fail = 0, n_loads = 0;
  logic [7:0] last_tx = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic pend = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_host_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rd_avail(rd_avail),
    .wr_room(wr_room), .baud_div(baud_div), .tx_load(tx_load), .tx_data(tx_data),
    .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_char(rx_char), .rx_pe(rx_pe), .rx_fe(rx_fe)
  );

  always @(posedge clk) if (tx_load) begin n_loads++; last_tx = tx_data; end

  always @(negedge clk) begin
    if (pend) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
      end
    end
    pend = bus_rd;
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, logic [15:0] e, string t);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rx(logic [7:0] c, logic pe, logic fe);
    @(posedge clk); #1;
    rx_valid = 1; rx_char = c; rx_pe = pe; rx_fe = fe;
    @(posedge clk); #1;
    rx_valid = 0; rx_pe = 0; rx_fe = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3); rst = 0; idle(1);
    // R13 reset state
    check("R13 irq", irq, 0);
    check("R13 tx_load", tx_load, 0);
    check("R13 rd_avail", rd_avail, 0);
    rd(3'd2, 16'h0060, "R13 status");
    rd(3'd3, 16'h0000, "R13 control");
    // R2 divisor
    check("R2 reset div", baud_div, 433);
    rd(3'd4, 16'd433, "R2 divisor reset read");
    wr(3'd4, 16'h1234);
    check("R2 baud_div", baud_div, 16'h1234);
    rd(3'd4, 16'h1234, "R2 divisor readback");
    // R1 unused offsets
    rd(3'd6, 16'h0000, "R1 offset 6");
    rd(3'd7, 16'h0000, "R1 offset 7");
    // R3 transmit hand-off
    wr(3'd1, 16'h005A);
    idle(3);
    check("R3 load count", n_loads, 1);
    check("R3 tx_data", last_tx, 8'h5A);
    check("R3 wr_room", wr_room, 1);
    rd(3'd1, 16'h0000, "R1 txdata reads zero");
    // R4 / R5 overrun with busy shifter
    tx_busy = 1;
    rd(3'd2, 16'h0040, "R5 busy not empty");
    wr(3'd1, 16'h0011);
    rd(3'd2, 16'h0000, "R3 holding full");
    check("R3 wr_room low", wr_room, 0);
    wr(3'd1, 16'h0022);
    idle(2);
    rd(3'd2, 16'h0110, "R4 overrun flagged");
    tx_busy = 0;
    idle(4);
    check("R4 load count", n_loads, 2);
    check("R4 kept char", last_tx, 8'h11);
    rd(3'd2, 16'h0170, "R5 empty again");
    wr(3'd2, 16'h0000);
    rd(3'd2, 16'h0060, "R10 clear toe");
    // R6 / R7 receive
    rx(8'h33, 0, 0);
    check("R6 rd_avail", rd_avail, 1);
    rd(3'd2, 16'h00E0, "R6 rrdy");
    rd(3'd0, 16'h0033, "R6 rxdata");
    rd(3'd2, 16'h0060, "R7 rrdy cleared");
    check("R7 rd_avail", rd_avail, 0);
    // R8 overrun
    rx(8'h44, 0, 0);
    rx(8'h55, 0, 0);
    rd(3'd2, 16'h01E8, "R8 roe");
    rd(3'd0, 16'h0055, "R8 overwrite");
    wr(3'd2, 16'hFFFF);
    rd(3'd2, 16'h0060, "R10 clear roe");
    // R9 errors
    rx(8'h66, 1, 1);
    rd(3'd2, 16'h01E3, "R9 pe fe err");
    rd(3'd0, 16'h0066, "R9 rxdata");
    wr(3'd2, 16'h0000);
    rd(3'd2, 16'h0060, "R10 clear pe fe");
    // R11 end of packet
    wr(3'd5, 16'h0077);
    rd(3'd5, 16'h0077, "R11 eop readback");
    rx(8'h77, 0, 0);
    rd(3'd2, 16'h10E0, "R11 rx eop");
    rd(3'd0, 16'h0077, "R11 rxdata");
    wr(3'd2, 16'h0000);
    rd(3'd2, 16'h0060, "R10 clear eop");
    wr(3'd1, 16'h0077);
    idle(4);
    check("R11 tx char", last_tx, 8'h77);
    rd(3'd2, 16'h1060, "R11 tx eop");
    wr(3'd2, 16'h0000);
    // R12 interrupts
    wr(3'd3, 16'h0040);
    idle(2);
    check("R12 irq on trdy", irq, 1);
    wr(3'd3, 16'h0080);
    idle(2);
    check("R12 irq masked", irq, 0);
    rx(8'h12, 0, 0);
    idle(1);
    check("R12 irq on rrdy", irq, 1);
    rd(3'd0, 16'h0012, "R12 rxdata");
    idle(2);
    check("R12 irq after read", irq, 0);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, 16'h11FB, "R12 control mask");
    wr(3'd3, 16'h0000);
    idle(3);
    check("R12 irq off", irq, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule